// File: doc/BRIEF.md
# Programmable Full-Scale Position Scaler

This block converts digitised position readings from several measurement channels into scaled output codes. Each channel has a 16-bit scale register that software writes. The register holds the fraction of mechanical travel, or of excitation in the two-wire hookup, that is to produce a full-scale reading. At the reset value of FFFFh, full travel gives full scale. Smaller values stretch a shorter stroke across the whole output range, and any reading beyond the programmed travel is clamped to the top code.

A sample arrives as one raw code per channel, qualified by a single strobe. Two clocks later the block delivers one scaled code per channel, with its own strobe. Each result is tagged with the wire-mode bit that was in force when its sample was taken. Software reaches the registers through a byte-wide write port. A scale word is written low byte first, then high byte, and takes effect as a whole when the high byte lands. A separate byte holds one wire-mode bit per channel.

Top module: `scl_top`

## Requirements
- R1: After reset every scale register is FFFFh, every wire-mode bit is 0, `out_valid` is 0 and `out_code` is all zeros.
- R2: With a scale of FFFFh, the output code equals the raw code for every raw value, including 0 and FFFFh.
- R3: When raw is not greater than the effective scale S, the output is floor(raw × 65535 / S). For example, S = 0100h and raw = 00FFh give FEFFh.
- R4: When raw is greater than the effective scale, the output is FFFFh. With S = 8000h, raw = 8000h already gives FFFFh and raw = 4000h gives 7FFFh.
- R5: A scale register holding 0000h acts exactly as FFFFh.
- R6: The scale of channel c is written through byte address 2c (low byte) and byte address 2c+1 (high byte). A low-byte write alone changes no scale. The high-byte write commits the high byte together with the most recently written low byte.
- R7: The wire-mode byte sits at address 10h, with bit c for channel c (1 = two-wire, 0 = three/four-wire). `out_mode` bit c gives the mode that was captured with the sample.
- R8: `out_valid` is high exactly two clocks after each cycle in which `smp_valid` is high. While no new result is due, `out_code` and `out_mode` hold their values.
- R9: A scale write that commits on the same clock edge as a sample is taken does not affect that sample. It applies from the next sample on.
- R10: Channels are independent: writing one channel's scale leaves the results of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | 8 | Register write byte |
| smp_valid | input | 1 | Raw sample strobe |
| smp_raw | input | NUM_CH×16 (64) | Raw position codes, channel 0 in the low bits |
| out_valid | output | 1 | Scaled result strobe |
| out_code | output | NUM_CH×16 (64) | Scaled, saturated codes, channel 0 in the low bits |
| out_mode | output | NUM_CH (4) | Wire-mode tag for each channel of the result |

## Verification
A scale register can commit its high byte on the same edge at which a sample is captured. The bench provokes this by driving `reg_wr` for a high-byte address together with `smp_valid` in a single cycle. The scoreboard expects that sample to be scaled with the old register value and the next sample with the new one. A one-channel difference between the two results shows whether the capture and the commit were ordered correctly.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int CODE_W = 16;
    localparam logic [CODE_W-1:0] FULL_CODE = '1;

    typedef logic [CODE_W-1:0] code_t;

    // Capture stage: sample and scale snapshot
    typedef struct packed {
        code_t raw;
        code_t scale;
        logic  mode;
    } cap_t;

    // Result stage
    typedef struct packed {
        code_t code;
        logic  mode;
    } res_t;

    typedef struct packed {
        cap_t cap;
        res_t res;
    } lane_t;
endpackage

// File: rtl/scl_regs.sv
module scl_regs
    import scl_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int MODE_ADDR = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    output logic [NUM_CH*CODE_W-1:0] scale_flat,
    output logic [NUM_CH-1:0]        mode_bits
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] scale;
        logic [7:0]                    lo;
        logic [NUM_CH-1:0]             mode;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(2 * ch))
                    regs_d.lo = wr_data;
                if (wr_addr == ADDR_W'(2 * ch + 1))
                    regs_d.scale[ch] = {wr_data, regs_q.lo};
            end
            if (wr_addr == ADDR_W'(MODE_ADDR))
                regs_d.mode = wr_data[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.scale <= {NUM_CH{FULL_CODE}};
            regs_q.lo    <= 8'hFF;
            regs_q.mode  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign scale_flat = regs_q.scale;
    assign mode_bits  = regs_q.mode;
endmodule

// File: rtl/scl_lane.sv
module scl_lane
    import scl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_en,
    input  logic  adv_en,
    input  code_t raw,
    input  code_t scale,
    input  logic  mode,
    output code_t code,
    output logic  mode_o
);
    lane_t lane_d, lane_q;

    always_comb begin
        logic [2*CODE_W-1:0] prod;
        lane_d = lane_q;
        prod   = {{CODE_W{1'b0}}, lane_q.cap.raw} * {{CODE_W{1'b0}}, FULL_CODE};
        if (cap_en) begin
            lane_d.cap.raw   = raw;
            lane_d.cap.scale = (scale == '0) ? FULL_CODE : scale;
            lane_d.cap.mode  = mode;
        end
        if (adv_en) begin
            if (lane_q.cap.raw > lane_q.cap.scale)
                lane_d.res.code = FULL_CODE;
            else
                lane_d.res.code = CODE_W'(prod / {{CODE_W{1'b0}}, lane_q.cap.scale});
            lane_d.res.mode = lane_q.cap.mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q.cap.raw   <= '0;
            lane_q.cap.scale <= FULL_CODE;
            lane_q.cap.mode  <= 1'b0;
            lane_q.res       <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign code   = lane_q.res.code;
    assign mode_o = lane_q.res.mode;
endmodule

// File: rtl/scl_top.sv
module scl_top
    import scl_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int MODE_ADDR = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [7:0]               reg_wdata,
    input  logic                     smp_valid,
    input  logic [NUM_CH*CODE_W-1:0] smp_raw,
    output logic                     out_valid,
    output logic [NUM_CH*CODE_W-1:0] out_code,
    output logic [NUM_CH-1:0]        out_mode
);
    typedef struct packed {
        logic cap_v;
        logic res_v;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_CH*CODE_W-1:0] scale_flat;
    logic [NUM_CH-1:0]        mode_bits;

    scl_regs #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .scale_flat(scale_flat),
        .mode_bits (mode_bits)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.cap_v = smp_valid;
        ctrl_d.res_v = ctrl_q.cap_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        scl_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_en(smp_valid),
            .adv_en(ctrl_q.cap_v),
            .raw   (smp_raw[ch*CODE_W +: CODE_W]),
            .scale (scale_flat[ch*CODE_W +: CODE_W]),
            .mode  (mode_bits[ch]),
            .code  (out_code[ch*CODE_W +: CODE_W]),
            .mode_o(out_mode[ch])
        );
    end

    assign out_valid = ctrl_q.res_v;
endmodule

// File: rtl/scl_chk.sv
module scl_chk #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int MODE_ADDR = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [7:0]           reg_wdata,
    input logic                 smp_valid,
    input logic                 out_valid,
    input logic [NUM_CH*16-1:0] out_code,
    input logic [NUM_CH*16-1:0] scale_flat,
    input logic [NUM_CH-1:0]    mode_bits
);
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ##2 out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ##2 (!out_valid && $stable(out_code)));

    p_lowbyte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr[0] && (reg_addr < ADDR_W'(2 * NUM_CH))) |=> $stable(scale_flat));

    p_highbyte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1)) |=> (scale_flat[15:8] == $past(reg_wdata)));

    p_modebyte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(MODE_ADDR)) |=> (mode_bits == $past(reg_wdata[NUM_CH-1:0])));
endmodule

bind scl_top scl_chk #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .smp_valid (smp_valid),
    .out_valid (out_valid),
    .out_code  (out_code),
    .scale_flat(scale_flat),
    .mode_bits (mode_bits)
);

// File: tb/scl_top_test.sv
`timescale 1ns/1ps
module scl_top_test;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic            smp_valid = 1'b0;
    logic [NCH*16-1:0] smp_raw = '0;
    logic            out_valid;
    logic [NCH*16-1:0] out_code;
    logic [NCH-1:0]  out_mode;

    always #2.5 clk = ~clk;

    scl_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .out_valid(out_valid), .out_code(out_code), .out_mode(out_mode)
    );

    typedef struct {
        logic [NCH*16-1:0] code;
        logic [NCH-1:0]    mode;
        string             tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;

    // bench model of the registers, from the requirements
    logic [15:0]    m_scale [NCH];
    logic [7:0]     m_lo;
    logic [NCH-1:0] m_mode;
    logic [NCH*16-1:0] last_code;

    function automatic logic [15:0] expect_code(input logic [15:0] raw, input logic [15:0] sc);
        logic [15:0] s;
        logic [31:0] q;
        s = (sc == 16'h0) ? 16'hFFFF : sc;
        if (raw > s) return 16'hFFFF;
        q = (32'(raw) * 32'd65535) / 32'(s);
        return q[15:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input logic [NCH*16-1:0] raw, input string tag);
        exp_t e;
        for (int c = 0; c < NCH; c++)
            e.code[c*16 +: 16] = expect_code(raw[c*16 +: 16], m_scale[c]);
        e.mode = m_mode;
        e.tag  = tag;
        return e;
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(2*c))   m_lo = d;
            if (a == 8'(2*c+1)) m_scale[c] = {d, m_lo};
        end
        if (a == 8'h10) m_mode = d[NCH-1:0];
    endfunction

    // all tasks start and end at a falling edge
    task automatic idle(input int n);
        smp_valid = 1'b0;
        reg_wr    = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        model_wr(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic smp(input logic [NCH*16-1:0] raw, input string tag);
        smp_valid = 1'b1; smp_raw = raw;
        sb.push_back(make_exp(raw, tag));
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic smp_wr(input logic [NCH*16-1:0] raw, input logic [7:0] a,
                          input logic [7:0] d, input string tag);
        smp_valid = 1'b1; smp_raw = raw;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        sb.push_back(make_exp(raw, tag));
        model_wr(a, d);
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                for (int c = 0; c < NCH; c++)
                    check($sformatf("%s ch%0d code", e.tag, c),
                          64'(out_code[c*16 +: 16]), 64'(e.code[c*16 +: 16]));
                check($sformatf("%s mode R7", e.tag), 64'(out_mode), 64'(e.mode));
                last_code = e.code;
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_scale[c] = 16'hFFFF;
        m_lo = 8'hFF; m_mode = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 out_code after reset", 64'(out_code), 64'd0);
        check("R1 out_mode after reset", 64'(out_mode), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 default scale passes raw through; also R1 reset scale
        smp({16'h8000, 16'h0000, 16'hFFFF, 16'h1234}, "R2 R1 identity");
        smp({16'h0001, 16'hFFFF, 16'h0000, 16'hABCD}, "R2 identity b");
        idle(3);

        // R8 latency probe: single sample, watch strobe cycle by cycle
        smp({16'h0100, 16'h0200, 16'h0300, 16'h0400}, "R8 probe");
        check("R8 strobe one clock after", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R8 strobe two clocks after", 64'(out_valid), 64'd1);
        @(negedge clk);
        check("R8 strobe drops", 64'(out_valid), 64'd0);
        idle(2);
        check("R8 code held", 64'(out_code), 64'(last_code));

        // R4 and R10: half-travel scale on channel 0 only
        wr(8'h00, 8'h00);
        wr(8'h01, 8'h80);
        smp({16'h1111, 16'h2222, 16'h3333, 16'h4000}, "R4 R10 half travel");
        smp({16'h1111, 16'h2222, 16'h3333, 16'h8000}, "R4 at travel");
        smp({16'h1111, 16'h2222, 16'h3333, 16'h8001}, "R4 past travel");

        // R3 small scale on channel 1
        wr(8'h02, 8'h00);
        wr(8'h03, 8'h01);
        smp({16'h0, 16'h0, 16'h00FF, 16'h0}, "R3 ratio FEFF");
        smp({16'h0, 16'h0, 16'h0080, 16'h0}, "R3 ratio 7FFF");

        // R5 zero scale on channel 2
        wr(8'h04, 8'h00);
        wr(8'h05, 8'h00);
        smp({16'h0, 16'h1234, 16'h0, 16'h0}, "R5 zero scale");

        // R6 low byte alone has no effect, high byte commits
        wr(8'h06, 8'h00);
        smp({16'h2000, 16'h0, 16'h0, 16'h0}, "R6 low byte ignored");
        wr(8'h07, 8'h40);
        smp({16'h2000, 16'h0, 16'h0, 16'h0}, "R6 high byte commits");

        // R7 wire-mode tags
        wr(8'h10, 8'h05);
        smp({16'h0001, 16'h0002, 16'h0003, 16'h0004}, "R7 modes 0101");
        wr(8'h10, 8'h0A);
        smp({16'h0001, 16'h0002, 16'h0003, 16'h0004}, "R7 modes 1010");

        // R9 commit on same edge as a sample
        wr(8'h00, 8'h00);
        smp_wr({16'h0, 16'h0, 16'h0, 16'h4000}, 8'h01, 8'h40, "R9 old scale");
        smp({16'h0, 16'h0, 16'h0, 16'h4000}, "R9 new scale");

        // R8 back-to-back samples
        smp_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            smp_raw = {4{16'(k * 16'h1000)}};
            sb.push_back(make_exp(smp_raw, "R8 back to back"));
            @(negedge clk);
        end
        smp_valid = 1'b0;

        idle(6);
        check("R8 scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule